// File: doc/BRIEF.md
# I2C Target Byte Engine

This block is the serial byte path of an I2C target. It watches the bus SCL and SDA lines, passes them through a synchronizer, and finds clock edges and START/STOP conditions in the system clock domain. It shifts bytes in and out most significant bit first. It compares each address byte that follows a START with a programmable 7-bit own address, and can optionally accept the general-call address. On a match it acknowledges and then serves a write transfer or a read transfer, depending on the direction bit.

After every accepted byte it raises a byte-complete flag. While that flag is set it holds SCL low, so the bus waits, and the data register stays frozen for the host. The host side is a small register port: a data register, an address register, a shared write-data bus and a strobe that clears the flag.

Top module: `i2ct_target`

## Requirements
- R1: After a synchronous reset, `dat_q` and `adr_q` are 00h, `flag` is 0, and neither `sda_oe` nor `scl_hold` is asserted.
- R2: Received bytes are shifted MSB first. The first bit sampled on SCL rising lands in bit 7 of `dat_q`.
- R3: In a read transfer the first bit driven onto SDA is bit 7 of the data register. The remaining bits follow in falling bit order.
- R4: An address byte after a START is accepted when bits 7..1 equal `adr_q[7:1]`. On acceptance the block pulls SDA low for the ninth SCL period, `dat_q` takes the address byte, and `rw_dir` takes its bit 0 (1 = target transmits).
- R5: On an address mismatch the block gives no acknowledge and does not set `flag`. It then ignores every further byte until the next START.
- R6: The address byte 00h is accepted as a general call only when `adr_q[0]` is 1. Otherwise it is treated as a mismatch.
- R7: `flag` is set only by hardware, after the ninth SCL falling edge of an accepted byte. It is cleared only by `clr_flag`. `scl_hold` is asserted while `flag` is set.
- R8: A `wr_dat` strobe updates `dat_q` only while `flag` is 1. At any other time it has no effect.
- R9: While `flag` is set, bus activity does not change `dat_q` or `flag`.
- R10: A START returns the block to waiting for an address byte, even in the middle of a byte. A STOP returns it to idle, and data bytes are then ignored until a START.
- R11: Each data byte received in a write transfer is acknowledged, and its value appears in `dat_q`.
- R12: In a read transfer, a master not-acknowledge makes the block release SDA, leave `flag` clear and go idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus SCL level |
| sda_i | input | 1 | Bus SDA level |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_hold | output | 1 | 1 pulls SCL low (byte waiting for host) |
| wr_dat | input | 1 | Data register write strobe |
| wr_adr | input | 1 | Address register write strobe |
| wdata | input | 8 | Host write data for both registers |
| clr_flag | input | 1 | Byte-complete flag clear strobe |
| dat_q | output | 8 | Data register |
| adr_q | output | 8 | Own address in bits 7..1, general-call enable in bit 0 |
| flag | output | 1 | Byte-complete flag |
| rw_dir | output | 1 | Direction bit of the last accepted address |

## Verification
The hardest case to reach is a bus that keeps clocking while the flag is set. A compliant master cannot do this, because the held SCL stops it. The bench therefore opens its SCL model so that `scl_hold` is disregarded, and toggles SCL and SDA while the flag is up. It then checks that the data register and the flag have not moved. A repeated START in the middle of a byte, and a master not-acknowledge at the end of a read, are also driven on purpose to reach the paths that abandon a byte.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);
    localparam int CNT_W  = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] ACK_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] END_CNT = CNT_W'(BYTE_W + 1);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_RX   = 2'd2,
        PH_TX   = 2'd3
    } phase_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic              done;
        logic              load;
        logic [BYTE_W-1:0] value;
    } byte_evt_t;

    // An all-zero address field is the general call: honoured only with enable set and write direction.
    function automatic logic addr_accept(input logic [BYTE_W-1:0] rx, input logic [BYTE_W-1:0] own);
        if (rx[BYTE_W-1:1] == '0)
            return own[0] && !rx[0];
        return rx[BYTE_W-1:1] == own[BYTE_W-1:1];
    endfunction

endpackage

// File: rtl/i2ct_bus_front.sv
module i2ct_bus_front
    import i2ct_pkg::*;
#(
    parameter int SYNC_LEN = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_pin,
    input  logic    sda_pin,
    output bus_ev_t ev
);

    localparam int LAST = SYNC_LEN - 1;

    // index 0 = SCL, index 1 = SDA
    logic [SYNC_LEN-1:0][1:0] stage;
    logic [1:0]               cur;
    logic [1:0]               prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '1;
            prev  <= 2'b11;
        end else begin
            stage[0] <= {sda_pin, scl_pin};
            for (int i = 1; i < SYNC_LEN; i++)
                stage[i] <= stage[i-1];
            prev <= cur;
        end
    end

    assign cur = stage[LAST];

    assign ev.scl_rise = cur[0] & ~prev[0];
    assign ev.scl_fall = ~cur[0] & prev[0];
    assign ev.start    = cur[0] & prev[0] & prev[1] & ~cur[1];
    assign ev.stop     = cur[0] & prev[0] & ~prev[1] & cur[1];
    assign ev.sda      = cur[1];

endmodule

// File: rtl/i2ct_byte_fsm.sv
module i2ct_byte_fsm
    import i2ct_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              hold,
    input  logic [BYTE_W-1:0] own_adr,
    input  logic              release_tx,
    input  logic [BYTE_W-1:0] tx_byte,
    output byte_evt_t         bev,
    output logic              sda_drv,
    output logic              rw_dir
);

    phase_t            ph;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] sh;
    logic              nack;
    logic [BYTE_W-1:0] rx_full;

    assign rx_full = {sh[BYTE_W-2:0], ev.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            bitcnt  <= '0;
            sh      <= '0;
            sda_drv <= 1'b0;
            rw_dir  <= 1'b0;
            nack    <= 1'b0;
            bev     <= '0;
        end else begin
            bev.done <= 1'b0;
            if (ev.start) begin
                ph      <= PH_ADDR;
                bitcnt  <= '0;
                sda_drv <= 1'b0;
            end else if (ev.stop) begin
                ph      <= PH_IDLE;
                bitcnt  <= '0;
                sda_drv <= 1'b0;
            end else if (release_tx) begin
                if (ph == PH_TX) begin
                    sh      <= tx_byte;
                    sda_drv <= ~tx_byte[BYTE_W-1];
                end
            end else if (!hold && ph != PH_IDLE) begin
                if (ev.scl_rise) begin
                    if (bitcnt < ACK_CNT) begin
                        bitcnt <= bitcnt + 1'b1;
                        if (ph != PH_TX)
                            sh <= rx_full;
                        if (ph == PH_ADDR && bitcnt == ACK_CNT - 1'b1) begin
                            if (addr_accept(rx_full, own_adr)) begin
                                rw_dir <= rx_full[0];
                            end else begin
                                ph     <= PH_IDLE;
                                bitcnt <= '0;
                            end
                        end
                    end else if (bitcnt == ACK_CNT) begin
                        bitcnt <= END_CNT;
                        nack   <= ev.sda;
                    end
                end else if (ev.scl_fall) begin
                    if (bitcnt == ACK_CNT) begin
                        sda_drv <= (ph != PH_TX);
                    end else if (bitcnt == END_CNT) begin
                        sda_drv <= 1'b0;
                        bitcnt  <= '0;
                        unique case (ph)
                            PH_ADDR: begin
                                ph        <= rw_dir ? PH_TX : PH_RX;
                                bev.done  <= 1'b1;
                                bev.load  <= 1'b1;
                                bev.value <= sh;
                            end
                            PH_RX: begin
                                bev.done  <= 1'b1;
                                bev.load  <= 1'b1;
                                bev.value <= sh;
                            end
                            PH_TX: begin
                                if (nack) begin
                                    ph <= PH_IDLE;
                                end else begin
                                    bev.done <= 1'b1;
                                    bev.load <= 1'b0;
                                end
                            end
                            default: ph <= PH_IDLE;
                        endcase
                    end else if (ph == PH_TX && bitcnt != '0) begin
                        sda_drv <= ~sh[IDX_W'(BYTE_W-1) - bitcnt[IDX_W-1:0]];
                    end
                end
            end
        end
    end

    // R10: a START always restarts the address phase from bit zero with SDA released
    p_start_restarts_r10: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (ph == PH_ADDR && bitcnt == '0 && !sda_drv));

    // R4: in a receive phase the acknowledge begins only in the ninth clock slot
    p_ack_slot_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_drv) && ph != PH_TX) |-> bitcnt == ACK_CNT);

    // R5: nothing is driven while the block ignores the bus
    p_quiet_idle_r5: assert property (@(posedge clk) disable iff (rst)
        ph == PH_IDLE |-> !sda_drv);

    // R2: the bit counter never leaves the nine-slot frame
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        bitcnt <= END_CNT);

endmodule

// File: rtl/i2ct_host_regs.sv
module i2ct_host_regs
    import i2ct_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_dat,
    input  logic              wr_adr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              clr_flag,
    input  byte_evt_t         bev,
    output logic [BYTE_W-1:0] dat_q,
    output logic [BYTE_W-1:0] adr_q,
    output logic              flag,
    output logic              release_tx,
    output logic [BYTE_W-1:0] tx_byte
);

    logic host_write_ok;

    assign host_write_ok = wr_dat & flag;
    assign release_tx    = clr_flag & flag;
    // a write in the same cycle as the clear is the byte that goes out
    assign tx_byte       = host_write_ok ? wdata : dat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dat_q <= '0;
            adr_q <= '0;
            flag  <= 1'b0;
        end else begin
            if (wr_adr)
                adr_q <= wdata;
            if (bev.done) begin
                flag <= 1'b1;
                if (bev.load)
                    dat_q <= bev.value;
            end else begin
                if (host_write_ok)
                    dat_q <= wdata;
                if (clr_flag)
                    flag <= 1'b0;
            end
        end
    end

    // R9: with the flag up only the host may alter the data register
    p_dat_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (flag && !wr_dat) |=> $stable(dat_q));

    // R8: host writes with the flag down leave the data register alone
    p_dat_gated_r8: assert property (@(posedge clk) disable iff (rst)
        (!flag && !bev.done) |=> $stable(dat_q));

    // R7: the flag drops only on the clear strobe
    p_flag_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(clr_flag));

    // R7: the engine never completes a byte while the host still owns the last one
    p_no_overrun_r7: assert property (@(posedge clk) disable iff (rst)
        bev.done |-> !flag);

endmodule

// File: rtl/i2ct_target.sv
module i2ct_target
    import i2ct_pkg::*;
#(
    parameter int SYNC_LEN = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic       scl_hold,
    input  logic       wr_dat,
    input  logic       wr_adr,
    input  logic [7:0] wdata,
    input  logic       clr_flag,
    output logic [7:0] dat_q,
    output logic [7:0] adr_q,
    output logic       flag,
    output logic       rw_dir
);

    bus_ev_t           ev;
    byte_evt_t         bev;
    logic              release_tx;
    logic [BYTE_W-1:0] tx_byte;

    i2ct_bus_front #(.SYNC_LEN(SYNC_LEN)) u_front (
        .clk     (clk),
        .rst     (rst),
        .scl_pin (scl_i),
        .sda_pin (sda_i),
        .ev      (ev)
    );

    i2ct_byte_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .hold       (flag),
        .own_adr    (adr_q),
        .release_tx (release_tx),
        .tx_byte    (tx_byte),
        .bev        (bev),
        .sda_drv    (sda_oe),
        .rw_dir     (rw_dir)
    );

    i2ct_host_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_dat     (wr_dat),
        .wr_adr     (wr_adr),
        .wdata      (wdata),
        .clr_flag   (clr_flag),
        .bev        (bev),
        .dat_q      (dat_q),
        .adr_q      (adr_q),
        .flag       (flag),
        .release_tx (release_tx),
        .tx_byte    (tx_byte)
    );

    assign scl_hold = flag;

endmodule

// File: tb/sim_i2ct_target.sv
`timescale 1ns/1ps
module sim_i2ct_target;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       honor = 1'b1;
    logic       wr_dat = 1'b0;
    logic       wr_adr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       clr_flag = 1'b0;
    logic       sda_oe;
    logic       scl_hold;
    logic [7:0] dat_q;
    logic [7:0] adr_q;
    logic       flag;
    logic       rw_dir;
    logic       scl_bus;
    logic       sda_bus;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         ended = 1'b0;

    assign scl_bus = m_scl & ~(scl_hold & honor);
    assign sda_bus = m_sda & ~sda_oe;

    always #2.5 clk = ~clk;

    i2ct_target u0 (
        .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
        .sda_oe(sda_oe), .scl_hold(scl_hold), .wr_dat(wr_dat), .wr_adr(wr_adr),
        .wdata(wdata), .clr_flag(clr_flag), .dat_q(dat_q), .adr_q(adr_q),
        .flag(flag), .rw_dir(rw_dir)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl = 1'b1;
        while (scl_bus !== 1'b1) tick(1);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;
        tick(Q);
        scl_up();
        tick(Q);
        m_scl = 1'b0;
        tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1;
        tick(Q);
        scl_up();
        tick(Q/2);
        b = sda_bus;
        tick(Q/2);
        m_scl = 1'b0;
        tick(Q);
    endtask

    task automatic bus_start();
        m_sda = 1'b1;
        tick(Q);
        scl_up();
        tick(Q);
        m_sda = 1'b0;
        tick(Q);
        m_scl = 1'b0;
        tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0;
        tick(Q);
        scl_up();
        tick(Q);
        m_sda = 1'b1;
        tick(Q);
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(ack);
    endtask

    task automatic read_byte(input logic ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(ack);
    endtask

    task automatic host_dat(input logic [7:0] v);
        wdata = v; wr_dat = 1'b1; tick(1); wr_dat = 1'b0; tick(1);
    endtask

    task automatic host_adr(input logic [7:0] v);
        wdata = v; wr_adr = 1'b1; tick(1); wr_adr = 1'b0; tick(1);
    endtask

    task automatic host_clr();
        clr_flag = 1'b1; tick(1); clr_flag = 1'b0; tick(1);
    endtask

    task automatic t_reset();
        chk("R1 dat", dat_q, 8'h00);
        chk("R1 adr", adr_q, 8'h00);
        chk("R1 flag", {7'd0, flag}, 8'h00);
        chk("R1 sda_oe", {7'd0, sda_oe}, 8'h00);
        chk("R1 scl_hold", {7'd0, scl_hold}, 8'h00);
    endtask

    task automatic t_gate();
        host_dat(8'h77);
        chk("R8 write ignored with flag clear", dat_q, 8'h00);
        host_adr(8'h84);
        chk("R4 own address stored", adr_q, 8'h84);
    endtask

    task automatic t_write();
        logic a;
        bus_start();
        write_byte(8'h84, a);
        chk("R4 address ack", {7'd0, a}, 8'h00);
        chk("R7 flag after address", {7'd0, flag}, 8'h01);
        chk("R4 address in dat", dat_q, 8'h84);
        chk("R4 rw_dir write", {7'd0, rw_dir}, 8'h00);
        chk("R7 scl_hold with flag", {7'd0, scl_hold}, 8'h01);
        honor = 1'b0;
        for (int i = 0; i < 3; i++) begin
            m_sda = i[0];
            tick(Q);
            m_scl = 1'b1;
            tick(Q);
            m_scl = 1'b0;
            tick(Q);
        end
        honor = 1'b1;
        chk("R9 dat frozen under bus activity", dat_q, 8'h84);
        chk("R9 flag kept under bus activity", {7'd0, flag}, 8'h01);
        host_dat(8'h3C);
        chk("R8 write accepted with flag set", dat_q, 8'h3C);
        host_clr();
        chk("R7 clear strobe", {7'd0, flag}, 8'h00);
        write_byte(8'hA5, a);
        chk("R11 data ack", {7'd0, a}, 8'h00);
        chk("R2 received A5", dat_q, 8'hA5);
        host_clr();
        write_byte(8'h01, a);
        chk("R11 second data ack", {7'd0, a}, 8'h00);
        chk("R2 received 01", dat_q, 8'h01);
        host_clr();
        bus_stop();
    endtask

    task automatic t_read();
        logic a;
        logic b;
        logic [7:0] v;
        bus_start();
        write_byte(8'h85, a);
        chk("R4 read address ack", {7'd0, a}, 8'h00);
        chk("R4 rw_dir read", {7'd0, rw_dir}, 8'h01);
        host_dat(8'hC3);
        host_clr();
        read_byte(1'b0, v);
        chk("R3 transmitted C3", v, 8'hC3);
        chk("R7 flag after transmitted byte", {7'd0, flag}, 8'h01);
        wdata = 8'h5A; wr_dat = 1'b1; clr_flag = 1'b1; tick(1);
        wr_dat = 1'b0; clr_flag = 1'b0; tick(1);
        read_byte(1'b1, v);
        chk("R3 transmitted 5A", v, 8'h5A);
        tick(Q);
        chk("R12 no flag after nack", {7'd0, flag}, 8'h00);
        chk("R12 sda released after nack", {7'd0, sda_oe}, 8'h00);
        v = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        chk("R12 idle after nack", v, 8'hFF);
        bus_stop();
    endtask

    task automatic t_miss();
        logic a;
        bus_start();
        write_byte(8'h90, a);
        chk("R5 mismatch not acked", {7'd0, a}, 8'h01);
        chk("R5 mismatch no flag", {7'd0, flag}, 8'h00);
        write_byte(8'h84, a);
        chk("R5 ignored until start", {7'd0, a}, 8'h01);
        chk("R5 ignored no flag", {7'd0, flag}, 8'h00);
        bus_stop();
    endtask

    task automatic t_gc();
        logic a;
        bus_start();
        write_byte(8'h00, a);
        chk("R6 general call off not acked", {7'd0, a}, 8'h01);
        bus_stop();
        host_adr(8'h85);
        bus_start();
        write_byte(8'h00, a);
        chk("R6 general call on acked", {7'd0, a}, 8'h00);
        chk("R6 general call flag", {7'd0, flag}, 8'h01);
        chk("R6 general call in dat", dat_q, 8'h00);
        host_clr();
        bus_stop();
    endtask

    task automatic t_restart();
        logic a;
        logic [7:0] v;
        bus_start();
        write_byte(8'h84, a);
        host_clr();
        bus_stop();
        write_byte(8'h84, a);
        chk("R10 byte after stop ignored", {7'd0, a}, 8'h01);
        chk("R10 no flag after stop", {7'd0, flag}, 8'h00);
        bus_start();
        write_byte(8'h84, a);
        host_clr();
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start();
        write_byte(8'h85, a);
        chk("R10 address after repeated start acked", {7'd0, a}, 8'h00);
        chk("R10 rw_dir after repeated start", {7'd0, rw_dir}, 8'h01);
        host_dat(8'h96);
        host_clr();
        read_byte(1'b1, v);
        chk("R3 transmitted 96", v, 8'h96);
        bus_stop();
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        tick(2);
        t_reset();
        t_gate();
        t_write();
        t_read();
        t_miss();
        t_gc();
        t_restart();
        tick(4);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
        finish_run();
    end

endmodule